// File: doc/BRIEF.md
# Multi-Mode Capture / Reload Timer

A 16-bit timer/counter with three operating modes, selected by a control field: capture, auto-reload, and up/down counting. It advances on one of two sources. The first is an internal clock-enable strobe. The second is falling edges on an external count pin, which passes through a synchronizer before use. A second external pin, the control pin, also passes through a synchronizer. Its meaning depends on the mode. In capture mode, a falling edge on it stores the count. In auto-reload mode, a falling edge on it reloads the counter. In up/down mode, its level sets the count direction.

Software sets up the block through a small write port. The port has four addresses: the counter, one shared reload/capture register, a control word, and a flag-clear strobe. A sticky overflow flag records every wrap of the counter. The block can also generate a clock. When clock-out is enabled, the count pin becomes an output, and that output toggles on every overflow. In this state the counter runs from the internal strobe.

Top module: `crt_timer`

## Requirements
- R1: After a synchronous reset, the counter, the reload/capture register, the overflow flag, the clock-out pin value and its output enable are all 0.
- R2: A write to address 0 (counter) loads the counter in the next cycle. This write takes priority over any count, reload or wrap in the same cycle.
- R3: In capture mode (control bits [1:0] = 0 or 3), a falling edge on the synchronized control pin copies the current count into the reload/capture register (address 1). The counter itself is not changed.
- R4: In auto-reload mode (bits [1:0] = 1), a falling edge on the synchronized control pin loads the counter from the reload register. Counting up past 0xFFFF also reloads the counter from that register and sets the flag.
- R5: In up/down mode (bits [1:0] = 2), a synchronized control level of 1 makes the counter count up. A level of 0 makes it count down.
- R6: With control bit 2 set and clock-out off, the counter advances once per falling edge on the synchronized count pin. The internal strobe is ignored in this state.
- R7: In capture mode, counting up from 0xFFFF gives 0x0000 and sets the overflow flag.
- R8: When counting down, a count event at a count equal to the reload register loads 0xFFFF and sets the overflow flag. At any other value the counter decrements.
- R9: With control bit 3 set, the output enable is 1. The clock-out pin toggles on each overflow and changes at no other time. The counter runs from the internal strobe.
- R10: The overflow flag stays set until a write to address 3 clears it.
- R11: With control bit 4 (run) clear, the counter changes only through writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 counter, 1 reload/capture, 2 control, 3 flag clear |
| wr_data | input | 16 | Write data |
| tick_en | input | 1 | Internal count strobe |
| cnt_pin_i | input | 1 | External count pin, input side |
| ctl_pin_i | input | 1 | External control pin |
| cnt_pin_o | output | 1 | Clock-out value for the count pin |
| cnt_pin_oe | output | 1 | Output enable for the count pin |
| count_o | output | 16 | Current count |
| regv_o | output | 16 | Reload/capture register |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Each mode is exercised with control-pin edges and with control-pin levels, so the tests show whether the block reacts to an edge or to a level. The internal strobe is held active while the block counts from the count pin, which shows that the strobe is ignored when the pin is the source. The counter is preloaded next to 0xFFFF and next to the reload value, so the tests can tell a plain wrap apart from a reload wrap and from a downward underflow. Some writes land in cycles where a count or a reload would also happen, to show which one wins.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_UPDOWN  = 2'd2,
    MODE_CAPALT  = 2'd3
  } mode_e;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_REG   = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_CLR   = 2'd3;

  localparam int CTRL_EXT_BIT  = 2;
  localparam int CTRL_CKO_BIT  = 3;
  localparam int CTRL_RUN_BIT  = 4;
  localparam int CTRL_W        = 5;
endpackage

// File: rtl/crt_sync.sv
module crt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic level,
  output logic fall
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-1:0], d};
  end

  assign level = sr[STAGES-1];
  assign fall  = sr[STAGES] & ~sr[STAGES-1];
endmodule

// File: rtl/crt_core.sv
module crt_core
  import crt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic         run,
  input  logic         cnt_evt,
  input  logic         dir_up,
  input  logic         ctl_fall,
  input  logic         wr_cnt,
  input  logic         wr_reg,
  input  logic         clr_flag,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic [W-1:0] regv,
  output logic         ovf_flag,
  output logic         ovf_evt
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic is_capture, is_reload, is_updown;
  logic going_up, at_max, at_floor, wrap, reload_hit;
  logic [W-1:0] count_nx;

  assign is_updown  = (mode == MODE_UPDOWN);
  assign is_reload  = (mode == MODE_RELOAD);
  assign is_capture = ~is_updown & ~is_reload;

  assign going_up   = is_updown ? dir_up : 1'b1;
  assign at_max     = (count == ALL_ONES);
  assign at_floor   = (count == regv);
  assign wrap       = going_up ? at_max : at_floor;
  assign reload_hit = run & is_reload & ctl_fall;
  assign ovf_evt    = run & cnt_evt & wrap & ~wr_cnt & ~reload_hit;

  always_comb begin
    count_nx = count;
    if (wr_cnt)                 count_nx = wr_data;
    else if (reload_hit)        count_nx = regv;
    else if (run && cnt_evt) begin
      if (going_up)             count_nx = at_max ? (is_capture ? '0 : regv) : count + 1'b1;
      else                      count_nx = at_floor ? ALL_ONES : count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      regv     <= '0;
      ovf_flag <= 1'b0;
    end else begin
      count <= count_nx;
      if (wr_reg)                       regv <= wr_data;
      else if (is_capture && ctl_fall)  regv <= count;
      if (ovf_evt)                      ovf_flag <= 1'b1;
      else if (clr_flag)                ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/crt_timer.sv
module crt_timer
  import crt_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         tick_en,
  input  logic         cnt_pin_i,
  input  logic         ctl_pin_i,
  output logic         cnt_pin_o,
  output logic         cnt_pin_oe,
  output logic [W-1:0] count_o,
  output logic [W-1:0] regv_o,
  output logic         ovf_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [1:0] mode;
  logic ext_src, clk_out_en, run;
  logic cnt_level, cnt_fall, ctl_level, ctl_fall;
  logic cnt_evt, dir_up, ovf_evt, clk_tgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      clk_tgl <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_CTRL) ctrl <= wr_data[CTRL_W-1:0];
      if (ovf_evt) clk_tgl <= ~clk_tgl;
    end
  end

  assign mode       = ctrl[1:0];
  assign ext_src    = ctrl[CTRL_EXT_BIT];
  assign clk_out_en = ctrl[CTRL_CKO_BIT];
  assign run        = ctrl[CTRL_RUN_BIT];

  crt_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .d(cnt_pin_i), .level(cnt_level), .fall(cnt_fall)
  );
  crt_sync #(.STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_pin_i), .level(ctl_level), .fall(ctl_fall)
  );

  assign cnt_evt = (ext_src && !clk_out_en) ? cnt_fall : tick_en;
  assign dir_up  = ctl_level;

  crt_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .mode(mode), .run(run), .cnt_evt(cnt_evt),
    .dir_up(dir_up), .ctl_fall(ctl_fall),
    .wr_cnt(wr_en && wr_addr == ADDR_COUNT),
    .wr_reg(wr_en && wr_addr == ADDR_REG),
    .clr_flag(wr_en && wr_addr == ADDR_CLR),
    .wr_data(wr_data), .count(count_o), .regv(regv_o),
    .ovf_flag(ovf_o), .ovf_evt(ovf_evt)
  );

  assign cnt_pin_o  = clk_out_en & clk_tgl;
  assign cnt_pin_oe = clk_out_en;

  logic unused_lvl;
  assign unused_lvl = cnt_level;
endmodule

// File: rtl/crt_checker.sv
module crt_checker
  import crt_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count_o,
  input logic [W-1:0] regv_o,
  input logic         ovf_o,
  input logic         cnt_pin_o,
  input logic         clk_out_en,
  input logic         ovf_evt,
  input logic         run,
  input logic         cnt_evt,
  input logic         dir_up,
  input logic [1:0]   mode
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count_o == '0 && regv_o == '0 && !ovf_o));

  p_write_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_COUNT) |=> count_o == $past(wr_data));

  p_down_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_evt && mode == MODE_UPDOWN && !dir_up && count_o == regv_o
     && !(wr_en && wr_addr == ADDR_COUNT)) |=> (count_o == '1 && ovf_o));

  p_clkout_r9: assert property (@(posedge clk) disable iff (rst)
    (clk_out_en && $past(clk_out_en) && !$stable(cnt_pin_o)) |-> $past(ovf_evt));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !(wr_en && wr_addr == ADDR_CLR)) |=> ovf_o);

  p_halt_r11: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && wr_addr == ADDR_COUNT)) |=> $stable(count_o));
endmodule

bind crt_timer crt_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .count_o(count_o), .regv_o(regv_o), .ovf_o(ovf_o), .cnt_pin_o(cnt_pin_o),
  .clk_out_en(clk_out_en), .ovf_evt(ovf_evt), .run(run), .cnt_evt(cnt_evt),
  .dir_up(dir_up), .mode(mode)
);

// File: tb/sim_crt_timer.sv
module sim_crt_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick_en = 1'b0;
  logic        cnt_pin_i = 1'b1;
  logic        ctl_pin_i = 1'b1;
  logic        cnt_pin_o, cnt_pin_oe, ovf_o;
  logic [15:0] count_o, regv_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_en(tick_en), .cnt_pin_i(cnt_pin_i), .ctl_pin_i(ctl_pin_i),
    .cnt_pin_o(cnt_pin_o), .cnt_pin_oe(cnt_pin_oe), .count_o(count_o),
    .regv_o(regv_o), .ovf_o(ovf_o)
  );

  // control word: run bit 4, clock-out bit 3, ext source bit 2, mode [1:0]
  function automatic logic [15:0] ctl_word(bit run, bit cko, bit ext, logic [1:0] m);
    return {11'd0, run, cko, ext, m};
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic ctl_set(logic v);
    ctl_pin_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 count", count_o, 16'h0);
    check("R1 reg", regv_o, 16'h0);
    check("R1 flags", {13'd0, ovf_o, cnt_pin_o, cnt_pin_oe}, 16'h0);
  endtask

  task automatic t_write_priority;
    wr(2, ctl_word(1, 0, 0, 2'd0));
    tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h1234;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 write beats tick", count_o, 16'h1234);
    @(negedge clk);
    tick_en = 1'b0;
    check("R2 counting resumes", count_o, 16'h1235);
  endtask

  task automatic t_halt;
    wr(2, ctl_word(0, 0, 0, 2'd0));
    wr(0, 16'h0042);
    ticks(5);
    check("R11 halted", count_o, 16'h0042);
  endtask

  task automatic t_capture_wrap;
    wr(2, ctl_word(1, 0, 0, 2'd0));
    wr(0, 16'hFFFE);
    ticks(1);
    check("R7 before wrap", {15'd0, ovf_o}, 16'h0);
    ticks(1);
    check("R7 wrap to zero", count_o, 16'h0000);
    check("R7 flag set", {15'd0, ovf_o}, 16'h1);
  endtask

  task automatic t_sticky;
    ticks(3);
    wr(2, ctl_word(1, 0, 0, 2'd0));
    check("R10 flag held", {15'd0, ovf_o}, 16'h1);
    wr(3, 16'h0);
    check("R10 flag cleared", {15'd0, ovf_o}, 16'h0);
  endtask

  task automatic t_capture;
    ctl_set(1'b1);
    wr(0, 16'h0100);
    ctl_set(1'b0);
    check("R3 captured", regv_o, 16'h0100);
    check("R3 count kept", count_o, 16'h0100);
  endtask

  task automatic t_reload;
    wr(2, ctl_word(1, 0, 0, 2'd1));
    wr(1, 16'h5000);
    wr(0, 16'h0007);
    ctl_set(1'b1);
    check("R4 no reload on rise", count_o, 16'h0007);
    ctl_set(1'b0);
    check("R4 reload on fall", count_o, 16'h5000);
    wr(3, 16'h0);
    wr(0, 16'hFFFF);
    ticks(1);
    check("R4 wrap reloads", count_o, 16'h5000);
    check("R4 wrap flag", {15'd0, ovf_o}, 16'h1);
  endtask

  task automatic t_updown;
    wr(2, ctl_word(1, 0, 0, 2'd2));
    ctl_set(1'b1);
    wr(1, 16'h0010);
    wr(0, 16'h0010);
    ticks(3);
    check("R5 up", count_o, 16'h0013);
    ctl_set(1'b0);
    ticks(2);
    check("R5 down", count_o, 16'h0011);
    wr(3, 16'h0);
    ticks(1);
    check("R8 plain decrement", count_o, 16'h0010);
    check("R8 no flag yet", {15'd0, ovf_o}, 16'h0);
    ticks(1);
    check("R8 underflow", count_o, 16'hFFFF);
    check("R8 flag", {15'd0, ovf_o}, 16'h1);
  endtask

  task automatic t_ext_count;
    wr(2, ctl_word(1, 0, 1, 2'd0));
    wr(0, 16'h0000);
    tick_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cnt_pin_i = 1'b1; repeat (4) @(negedge clk);
      cnt_pin_i = 1'b0; repeat (4) @(negedge clk);
    end
    tick_en = 1'b0;
    check("R6 pin edges counted", count_o, 16'h0003);
  endtask

  task automatic t_clkout;
    logic p0;
    wr(2, ctl_word(1, 1, 1, 2'd0));
    check("R9 oe", {15'd0, cnt_pin_oe}, 16'h1);
    p0 = cnt_pin_o;
    wr(0, 16'hFFFD);
    ticks(1);
    check("R9 strobe counts", count_o, 16'hFFFE);
    check("R9 no toggle", {15'd0, cnt_pin_o}, {15'd0, p0});
    ticks(2);
    check("R9 toggle 1", {15'd0, cnt_pin_o}, {15'd0, ~p0});
    wr(0, 16'hFFFF);
    ticks(1);
    check("R9 toggle 2", {15'd0, cnt_pin_o}, {15'd0, p0});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_priority();
    t_halt();
    t_capture_wrap();
    t_sticky();
    t_capture();
    t_reload();
    t_updown();
    t_ext_count();
    t_clkout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule